// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block holds a bank of six breakpoint pairs. Each pair is a 32-bit value register and a 32-bit control register. For every instruction address strobe it checks each enabled pair against the address, the processor mode, the security state and the current context identifier. It then reports a single hit together with the index of the lowest pair that fired. Software programs the pairs through a small synchronous register port. The debug logic of the core only consumes the registered hit pulse and the index.

A pair can match an address, with optional masking of low address bits and byte-lane qualification inside a word. It can fire on every address that such a match would reject. It can compare its full value against the context identifier. An address pair can also be made conditional on a context-identifier pair held elsewhere in the bank. Pairs 4 and 5 carry context-identifier comparators; pairs 0 to 3 do not.

Top module: `bkpt_match_unit`

## Requirements
- R1: After a synchronous reset, every register reads zero, every pair is disabled, and `bp_hit`/`bp_index` are 0.
- R2: A write with `cfg_we` stores `cfg_wdata` into the value register (`cfg_is_ctrl`=0) or the control register (`cfg_is_ctrl`=1) of pair `cfg_sel`. `cfg_rdata` shows the selected register one cycle after the request. Control bits 31:29, 23, 13:9 and 4:3 always read 0. A select of 6 or more ignores writes and reads 0.
- R3: Control bit 21 of pairs 0 to 3 always reads 0. Writing type 010 or 011 to those pairs therefore yields type 000 or 001.
- R4: Control fields are: enable at bit 0, mode condition at 2:1, byte lanes at 8:5 (bit 5+k selects byte k), security condition at 15:14, link pair at 19:16, type at 22:20, and mask at 28:24. Type 000 fires when address bits 31:2 equal value bits 31:2 outside the mask and the lane bit for `iva[1:0]` is set. `bp_hit`/`bp_index` are updated on the edge that samples `iva_valid`. They are 0 after an edge where `iva_valid` is low.
- R5: A mask value n from 3 to 31 removes address bits n-1:0 from the comparison. Mask values 0, 1 and 2 remove nothing beyond bits 1:0.
- R6: Type 100 fires exactly when the same pair programmed as type 000 would not fire. With byte lanes 0000 it fires on every address.
- R7: Security condition 00 passes in both states, 01 passes only when `cpu_secure`=0, 10 passes only when `cpu_secure`=1, and 11 never passes.
- R8: `cpu_mode` encodes 0=user, 1=supervisor, 2=system, 3=other privileged. Mode condition 00 passes modes 0, 1 and 2; 01 passes any mode but 0; 10 passes only mode 0; 11 passes all modes.
- R9: Type 010 (pairs 4 and 5 only) fires when the value equals `ctx_id` and both conditions pass. Type 011 never fires by itself.
- R10: Types 001 and 101 fire only when their own address result (match or mismatch) and conditions hold, and the linked pair also meets all of these: it is not the pair itself, it exists, it is enabled, it is of type 011, and its value equals `ctx_id`.
- R11: A disabled pair and a pair of type 110 or 111 never fire.
- R12: When several pairs fire, `bp_index` reports the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 4 | Pair select |
| cfg_is_ctrl | input | 1 | 1 selects the control register, 0 the value register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| iva_valid | input | 1 | Instruction address strobe |
| iva | input | 32 | Instruction virtual address |
| cpu_secure | input | 1 | 1 when the processor is in Secure state |
| cpu_mode | input | 2 | Processor mode class |
| ctx_id | input | 32 | Current context identifier |
| bp_hit | output | 1 | Registered breakpoint event |
| bp_index | output | 3 | Lowest pair index that fired |

## Verification
The hardest situation to reach is a linked pair firing. It needs an address pair of type 001 or 101 and a context pair of type 011 in pair 4 or 5, and the context pair must be enabled. The strobe must also carry the matching `ctx_id`. Directed stimulus builds this chain explicitly, then breaks one link at a time: a self link, an out-of-range link, a disabled target and a wrong context. A random phase draws values and addresses from a small pool so that linked, masked and mismatch configurations collide often, and a behavioural model is compared against the outputs on every clock.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned LINK_W = 4;

  // writable control bits: 28:24, 22:14, 8:5, 2:0
  localparam logic [DW-1:0] CTRL_WMASK = 32'h1F7F_C1E7;
  localparam int unsigned   CTX_BIT    = 21;

  localparam logic [2:0] MT_ADDR     = 3'b000;
  localparam logic [2:0] MT_ADDR_LNK = 3'b001;
  localparam logic [2:0] MT_CTX      = 3'b010;
  localparam logic [2:0] MT_CTX_LNK  = 3'b011;
  localparam logic [2:0] MT_MIS      = 3'b100;
  localparam logic [2:0] MT_MIS_LNK  = 3'b101;

  typedef enum logic [1:0] {
    MODE_USER  = 2'd0,
    MODE_SUPV  = 2'd1,
    MODE_SYS   = 2'd2,
    MODE_OTHER = 2'd3
  } cpu_mode_e;

  typedef struct packed {
    logic [4:0]        msk;
    logic [2:0]        mtype;
    logic [LINK_W-1:0] link;
    logic [1:0]        sec;
    logic [3:0]        lanes;
    logic [1:0]        mcond;
    logic              en;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [DW-1:0] r);
    ctrl_t c;
    c.msk   = r[28:24];
    c.mtype = r[22:20];
    c.link  = r[19:16];
    c.sec   = r[15:14];
    c.lanes = r[8:5];
    c.mcond = r[2:1];
    c.en    = r[0];
    return c;
  endfunction
endpackage

// File: rtl/bkpt_regbank.sv
module bkpt_regbank
  import bkpt_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 6,
  parameter int unsigned CTX_FIRST = 4,
  parameter int unsigned SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic             is_ctrl,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    ctrl_q  [NUM_PAIRS],
  output logic [DW-1:0]    value_q [NUM_PAIRS]
);
  localparam int unsigned IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  logic             sel_ok;
  logic [IDX_W-1:0] sel_idx;

  assign sel_ok  = (int'(sel) < int'(NUM_PAIRS));
  assign sel_idx = sel[IDX_W-1:0];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam logic [DW-1:0] KEEP = (p < CTX_FIRST) ?
                                     (CTRL_WMASK & ~(DW'(1) << CTX_BIT)) : CTRL_WMASK;
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[p]  <= '0;
        value_q[p] <= '0;
      end else if (we && (sel == SEL_W'(p))) begin
        if (is_ctrl) ctrl_q[p]  <= wdata & KEEP;
        else         value_q[p] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (!sel_ok) rdata <= '0;
    else if (is_ctrl) rdata <= ctrl_q[sel_idx];
    else              rdata <= value_q[sel_idx];
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(is_ctrl) |-> ((rdata & ~CTRL_WMASK) == '0)); // R2
endmodule

// File: rtl/bkpt_pair_eval.sv
module bkpt_pair_eval
  import bkpt_pkg::*;
#(
  parameter bit CTX_CAP = 1'b0
) (
  input  logic [DW-1:0] ctrl,
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] iva,
  input  logic          cpu_secure,
  input  logic [1:0]    cpu_mode,
  input  logic [DW-1:0] ctx_id,
  input  logic          link_ok,
  output logic          hit,
  output logic          lctx_ok
);
  ctrl_t         c;
  logic [DW-1:0] amask;
  logic          addr_eq, lane_ok, addr_hit;
  logic          sec_ok, mode_ok, state_ok, ctx_eq;

  assign c = decode_ctrl(ctrl);

  // mask of ignored low address bits; bits 1:0 are always ignored
  assign amask    = (c.msk >= 5'd3) ? ~({DW{1'b1}} << c.msk) : DW'(3);
  assign addr_eq  = (((iva ^ value) & ~amask) == '0);
  assign lane_ok  = c.lanes[iva[1:0]];
  assign addr_hit = addr_eq && lane_ok;

  if (CTX_CAP) begin : g_ctx
    assign ctx_eq = (value == ctx_id);
  end else begin : g_noctx
    assign ctx_eq = 1'b0;
  end

  always_comb begin
    unique case (c.sec)
      2'b00:   sec_ok = 1'b1;
      2'b01:   sec_ok = !cpu_secure;
      2'b10:   sec_ok = cpu_secure;
      default: sec_ok = 1'b0;
    endcase
    unique case (c.mcond)
      2'b00:   mode_ok = (cpu_mode != MODE_OTHER);
      2'b01:   mode_ok = (cpu_mode != MODE_USER);
      2'b10:   mode_ok = (cpu_mode == MODE_USER);
      default: mode_ok = 1'b1;
    endcase
  end

  assign state_ok = c.en && sec_ok && mode_ok;
  assign lctx_ok  = c.en && (c.mtype == MT_CTX_LNK) && ctx_eq;

  always_comb begin
    unique case (c.mtype)
      MT_ADDR:     hit = state_ok && addr_hit;
      MT_ADDR_LNK: hit = state_ok && addr_hit && link_ok;
      MT_CTX:      hit = state_ok && ctx_eq;
      MT_MIS:      hit = state_ok && !addr_hit;
      MT_MIS_LNK:  hit = state_ok && !addr_hit && link_ok;
      default:     hit = 1'b0;
    endcase
  end

  AST_RSVD_TYPE_QUIET: assert final (!(hit && (c.mtype[2:1] == 2'b11))); // R11
endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio #(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 6,
  parameter int unsigned CTX_FIRST = 4,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_is_ctrl,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             iva_valid,
  input  logic [31:0]      iva,
  input  logic             cpu_secure,
  input  logic [1:0]       cpu_mode,
  input  logic [31:0]      ctx_id,
  output logic             bp_hit,
  output logic [IDX_W-1:0] bp_index
);
  localparam int unsigned LINK_SPAN = 2 ** LINK_W;

  logic [DW-1:0]        ctrl_q  [NUM_PAIRS];
  logic [DW-1:0]        value_q [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] pair_hit, lctx_vec, link_ok;
  logic [LINK_SPAN-1:0] lctx_pad;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;

  bkpt_regbank #(
    .NUM_PAIRS(NUM_PAIRS), .CTX_FIRST(CTX_FIRST), .SEL_W(SEL_W)
  ) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .is_ctrl(cfg_is_ctrl),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl_q(ctrl_q), .value_q(value_q)
  );

  // unused link slots stay zero, so links past the bank never qualify
  assign lctx_pad = LINK_SPAN'(lctx_vec);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [LINK_W-1:0] lk;
    assign lk         = ctrl_q[p][19:16];
    assign link_ok[p] = lctx_pad[lk] && (lk != LINK_W'(p));

    bkpt_pair_eval #(.CTX_CAP(p >= CTX_FIRST)) eval_i (
      .ctrl(ctrl_q[p]), .value(value_q[p]), .iva(iva),
      .cpu_secure(cpu_secure), .cpu_mode(cpu_mode), .ctx_id(ctx_id),
      .link_ok(link_ok[p]), .hit(pair_hit[p]), .lctx_ok(lctx_vec[p])
    );
  end

  bkpt_prio #(.N(NUM_PAIRS), .IW(IDX_W)) prio_i (
    .req(pair_hit), .any(any_hit), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_hit   <= 1'b0;
      bp_index <= '0;
    end else begin
      bp_hit   <= iva_valid && any_hit;
      bp_index <= (iva_valid && any_hit) ? win_idx : '0;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> (int'(bp_index) < int'(NUM_PAIRS))); // R12
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> $past(iva_valid)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bp_hit && bp_index == '0)); // R1
  AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bp_hit |-> (bp_index == '0)); // R4
endmodule

// File: tb/bkpt_match_unit_tb.sv
`timescale 1ns/1ps
module bkpt_match_unit_tb_top;
  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic        cfg_is_ctrl = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        iva_valid = 1'b0;
  logic [31:0] iva = '0;
  logic        cpu_secure = 1'b0;
  logic [1:0]  cpu_mode = '0;
  logic [31:0] ctx_id = '0;
  logic        bp_hit;
  logic [2:0]  bp_index;

  always #2.5 clk = ~clk;

  bkpt_match_unit dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_is_ctrl(cfg_is_ctrl), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .iva_valid(iva_valid), .iva(iva), .cpu_secure(cpu_secure),
    .cpu_mode(cpu_mode), .ctx_id(ctx_id), .bp_hit(bp_hit), .bp_index(bp_index)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  bit    chk_on = 1'b0;
  string phase = "R1";

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_ctrl [NP];
  logic [31:0] m_val  [NP];
  logic        exp_hit;
  int          exp_idx;
  logic [31:0] exp_rd;

  function automatic bit lctx(int j, logic [31:0] c);
    if (j >= NP || j < 4) return 1'b0;
    return m_ctrl[j][0] && (m_ctrl[j][22:20] == 3'd3) && (m_val[j] == c);
  endfunction

  function automatic bit addr_hit(int i, logic [31:0] a);
    int          n = int'(m_ctrl[i][28:24]);
    logic [63:0] mk = (n >= 3) ? ((64'd1 << n) - 64'd1) : 64'd3;
    bit          eq = (((a ^ m_val[i]) & ~mk[31:0]) == 32'd0);
    return eq && m_ctrl[i][5 + int'(a[1:0])];
  endfunction

  function automatic bit fires(int i, logic [31:0] a, bit s, int md, logic [31:0] c);
    bit sok, mok, st, lk;
    int l;
    if (!m_ctrl[i][0]) return 1'b0;
    case (m_ctrl[i][15:14])
      2'd0: sok = 1; 2'd1: sok = !s; 2'd2: sok = s; default: sok = 0;
    endcase
    case (m_ctrl[i][2:1])
      2'd0: mok = (md != 3); 2'd1: mok = (md != 0); 2'd2: mok = (md == 0); default: mok = 1;
    endcase
    st = sok && mok;
    l  = int'(m_ctrl[i][19:16]);
    lk = (l != i) && lctx(l, c);
    case (m_ctrl[i][22:20])
      3'd0: return st && addr_hit(i, a);
      3'd1: return st && addr_hit(i, a) && lk;
      3'd2: return st && (i >= 4) && (m_val[i] == c);
      3'd4: return st && !addr_hit(i, a);
      3'd5: return st && !addr_hit(i, a) && lk;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++) begin m_ctrl[i] = '0; m_val[i] = '0; end
      exp_hit = 0; exp_idx = 0; exp_rd = '0;
    end else begin
      if (int'(cfg_sel) < NP) exp_rd = cfg_is_ctrl ? m_ctrl[cfg_sel] : m_val[cfg_sel];
      else                    exp_rd = '0;
      exp_hit = 0; exp_idx = 0;
      if (iva_valid)
        for (int i = NP - 1; i >= 0; i--)
          if (fires(i, iva, cpu_secure, int'(cpu_mode), ctx_id)) begin
            exp_hit = 1; exp_idx = i;
          end
      if (cfg_we && int'(cfg_sel) < NP) begin
        if (cfg_is_ctrl)
          m_ctrl[cfg_sel] = cfg_wdata & 32'h1F7F_C1E7 & ((int'(cfg_sel) < 4) ? 32'hFFDF_FFFF : 32'hFFFF_FFFF);
        else
          m_val[cfg_sel] = cfg_wdata;
      end
    end
    chk_on <= 1'b1;
  end

  // compare on every clock, away from the sampling edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (bp_hit !== exp_hit || int'(bp_index) != exp_idx) begin
        failures++;
        $display("FAIL %s model hit/idx actual=%0b/%0d expected=%0b/%0d",
                 phase, bp_hit, bp_index, exp_hit, exp_idx);
      end
      checks++;
      if (cfg_rdata !== exp_rd) begin
        failures++;
        $display("FAIL %s model rdata actual=%h expected=%h", phase, cfg_rdata, exp_rd);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(bit we, int sel, bit isc, logic [31:0] wd,
                       bit v, logic [31:0] a, bit s, int md, logic [31:0] c);
    @(negedge clk); #1;
    cfg_we = we; cfg_sel = 4'(sel); cfg_is_ctrl = isc; cfg_wdata = wd;
    iva_valid = v; iva = a; cpu_secure = s; cpu_mode = 2'(md); ctx_id = c;
  endtask

  task automatic wr(int sel, bit isc, logic [31:0] d);
    drive(1, sel, isc, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(int sel, bit isc);
    drive(0, sel, isc, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic st(logic [31:0] a, bit s, int md, logic [31:0] c);
    drive(0, 0, 0, 0, 1, a, s, md, c);
  endtask

  task automatic hand(bit h, int idx, string tag);
    @(negedge clk);
    checks++;
    if (bp_hit !== h || (h && int'(bp_index) != idx)) begin
      failures++;
      $display("FAIL %s directed hit/idx actual=%0b/%0d expected=%0b/%0d",
               tag, bp_hit, bp_index, h, idx);
    end
    #1 iva_valid = 0; cfg_we = 0;
  endtask

  task automatic hand_rd(logic [31:0] e, string tag);
    @(negedge clk);
    checks++;
    if (cfg_rdata !== e) begin
      failures++;
      $display("FAIL %s directed rdata actual=%h expected=%h", tag, cfg_rdata, e);
    end
  endtask

  function automatic logic [31:0] mk(bit en, int mc, int lanes, int sec, int lnk, int typ, int msk);
    return {3'b0, 5'(msk), 1'b0, 3'(typ), 4'(lnk), 2'(sec), 5'b0, 4'(lanes), 2'b0, 2'(mc), en};
  endfunction

  task automatic clr_all();
    for (int i = 0; i < NP; i++) wr(i, 1, 0);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    phase = "R1";
    rd(4, 1); hand_rd(32'h0, "R1");
    st(32'h0, 0, 3, 0); hand(0, 0, "R1");

    phase = "R2";
    wr(0, 0, 32'hDEAD_BEEF); rd(0, 0); hand_rd(32'hDEAD_BEEF, "R2");
    wr(5, 1, 32'hFFFF_FFFF); rd(5, 1); hand_rd(32'h1F7F_C1E7, "R2");
    wr(9, 0, 32'h1234_5678); rd(9, 0); hand_rd(32'h0, "R2");
    clr_all();

    phase = "R3";
    wr(1, 1, 32'hFFFF_FFFF); rd(1, 1); hand_rd(32'h1F5F_C1E7, "R3");
    wr(1, 1, mk(1, 3, 15, 0, 0, 2, 0)); wr(1, 0, 32'h40);
    st(32'h40, 0, 0, 0); hand(1, 1, "R3");
    clr_all();

    phase = "R4";
    wr(0, 0, 32'h1000); wr(0, 1, mk(1, 3, 15, 0, 0, 0, 0));
    st(32'h1002, 0, 0, 0); hand(1, 0, "R4");
    st(32'h1004, 0, 0, 0); hand(0, 0, "R4");
    wr(0, 1, mk(1, 3, 3, 0, 0, 0, 0));
    st(32'h1001, 0, 0, 0); hand(1, 0, "R4");
    st(32'h1002, 0, 0, 0); hand(0, 0, "R4");
    wr(0, 1, mk(1, 3, 12, 0, 0, 0, 0));
    st(32'h1003, 0, 0, 0); hand(1, 0, "R4");
    drive(0, 0, 0, 0, 0, 32'h1003, 0, 0, 0); hand(0, 0, "R4");

    phase = "R5";
    wr(0, 0, 32'h2000); wr(0, 1, mk(1, 3, 15, 0, 0, 0, 4));
    st(32'h200C, 0, 0, 0); hand(1, 0, "R5");
    st(32'h2010, 0, 0, 0); hand(0, 0, "R5");
    wr(0, 1, mk(1, 3, 15, 0, 0, 0, 1));
    st(32'h2004, 0, 0, 0); hand(0, 0, "R5");
    wr(0, 0, 32'h0); wr(0, 1, mk(1, 3, 15, 0, 0, 0, 31));
    st(32'h7FFF_FFF0, 0, 0, 0); hand(1, 0, "R5");
    st(32'h8000_0000, 0, 0, 0); hand(0, 0, "R5");

    phase = "R6";
    wr(0, 0, 32'h3000); wr(0, 1, mk(1, 3, 15, 0, 0, 4, 0));
    st(32'h3000, 0, 0, 0); hand(0, 0, "R6");
    st(32'h3004, 0, 0, 0); hand(1, 0, "R6");
    wr(0, 1, mk(1, 3, 0, 0, 0, 4, 0));
    st(32'h3000, 0, 0, 0); hand(1, 0, "R6");

    phase = "R7";
    wr(0, 0, 32'h1000); wr(0, 1, mk(1, 3, 15, 1, 0, 0, 0));
    st(32'h1000, 1, 0, 0); hand(0, 0, "R7");
    st(32'h1000, 0, 0, 0); hand(1, 0, "R7");
    wr(0, 1, mk(1, 3, 15, 2, 0, 0, 0));
    st(32'h1000, 1, 0, 0); hand(1, 0, "R7");
    wr(0, 1, mk(1, 3, 15, 3, 0, 0, 0));
    st(32'h1000, 0, 0, 0); hand(0, 0, "R7");

    phase = "R8";
    wr(0, 1, mk(1, 2, 15, 0, 0, 0, 0));
    st(32'h1000, 0, 1, 0); hand(0, 0, "R8");
    st(32'h1000, 0, 0, 0); hand(1, 0, "R8");
    wr(0, 1, mk(1, 0, 15, 0, 0, 0, 0));
    st(32'h1000, 0, 3, 0); hand(0, 0, "R8");
    st(32'h1000, 0, 2, 0); hand(1, 0, "R8");
    wr(0, 1, mk(1, 1, 15, 0, 0, 0, 0));
    st(32'h1000, 0, 0, 0); hand(0, 0, "R8");
    clr_all();

    phase = "R9";
    wr(4, 0, 32'hCAFE); wr(4, 1, mk(1, 3, 15, 0, 0, 2, 0));
    st(32'h0, 0, 0, 32'hCAFE); hand(1, 4, "R9");
    st(32'h0, 0, 0, 32'hCAFF); hand(0, 0, "R9");
    wr(4, 1, mk(1, 3, 15, 0, 0, 3, 0));
    st(32'h0, 0, 0, 32'hCAFE); hand(0, 0, "R9");
    clr_all();

    phase = "R10";
    wr(4, 0, 32'h55); wr(4, 1, mk(1, 3, 15, 0, 0, 3, 0));
    wr(1, 0, 32'h1000); wr(1, 1, mk(1, 3, 15, 0, 4, 1, 0));
    st(32'h1000, 0, 0, 32'h55); hand(1, 1, "R10");
    st(32'h1000, 0, 0, 32'h56); hand(0, 0, "R10");
    wr(1, 1, mk(1, 3, 15, 0, 1, 1, 0));
    st(32'h1000, 0, 0, 32'h55); hand(0, 0, "R10");
    wr(1, 1, mk(1, 3, 15, 0, 9, 1, 0));
    st(32'h1000, 0, 0, 32'h55); hand(0, 0, "R10");
    wr(1, 1, mk(1, 3, 15, 0, 4, 5, 0));
    st(32'h2000, 0, 0, 32'h55); hand(1, 1, "R10");
    st(32'h1000, 0, 0, 32'h55); hand(0, 0, "R10");
    wr(4, 1, mk(0, 3, 15, 0, 0, 3, 0));
    st(32'h2000, 0, 0, 32'h55); hand(0, 0, "R10");
    clr_all();

    phase = "R11";
    wr(5, 0, 32'h0); wr(5, 1, mk(1, 3, 0, 0, 0, 6, 0));
    st(32'h0, 0, 0, 32'h0); hand(0, 0, "R11");
    wr(5, 1, mk(1, 3, 15, 0, 0, 7, 0));
    st(32'h4, 0, 0, 32'h0); hand(0, 0, "R11");
    wr(0, 0, 32'h1000); wr(0, 1, mk(0, 3, 15, 0, 0, 0, 0));
    st(32'h1000, 0, 0, 0); hand(0, 0, "R11");
    clr_all();

    phase = "R12";
    wr(2, 0, 32'h1000); wr(2, 1, mk(1, 3, 15, 0, 0, 0, 0));
    wr(0, 0, 32'h1000); wr(0, 1, mk(1, 3, 15, 0, 0, 0, 0));
    st(32'h1000, 0, 0, 0); hand(1, 0, "R12");
    wr(0, 1, 0);
    st(32'h1000, 0, 0, 0); hand(1, 2, "R12");

    // mixed random traffic over a small value pool, model compared each clock
    for (int k = 0; k < 4000; k++) begin
      int sel = int'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1) == 0)
          drive(1, sel, 1, $urandom(), 0, 0, 0, 0, 0);
        else
          drive(1, sel, 0, {28'h0, 4'($urandom_range(0, 15))} << 2, 0, 0, 0, 0, 0);
      end else begin
        drive($urandom_range(0, 1) == 0, sel, $urandom_range(0, 1) == 1,
              32'($urandom_range(0, 3)),
              $urandom_range(0, 3) != 0, 32'($urandom_range(0, 63)),
              $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)),
              32'($urandom_range(0, 3)));
      end
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule